// File: doc/BRIEF.md
# Registered Read-Only Memory with Configurable Front End

This block is a byte-wide read-only memory whose read data leaves through an edge-triggered output register. At each rising clock edge the word at the effective address is captured, and the data output shows that register. Data reaches the output one clock after the address is presented.

Three static configuration inputs shape the front end:

- One selects how the active-low output enable behaves. It can gate the output drive directly, or it can be sampled on the clock.
- One chooses the address path. The address either flows straight into the array, or it passes through a level-sensitive latch.
- One sets the level at which the latch is open.

The block has no tri-state outputs. A separate drive indication reports whether the data is valid, and the data bits read as zero whenever the drive indication is low. A test-only program port fills the array. The full-size part, 32768 words, uses `ADDR_W = 15`. The default is 11, which keeps elaboration light.

Top module: `registered_rom`

## Requirements
- R1: The array holds 2**ADDR_W words of 8 bits. While `prog_mode` is 1, a rising clock edge with `prog_we` = 1 writes `prog_data` to word `prog_addr`.
- R2: While `prog_mode` is 0, every rising clock edge loads the word at the effective address into the output register. The output register appears on `dout` whenever `drive` is 1.
- R3: A low `rst_n`, with no clock needed, does three things: it clears the output register to 0x00, it sets the sampled enable to the disabled state, and it clears the held address to 0.
- R4: With `cfg_sync_oe` = 0, `drive` equals the inverse of `oe_n` at all times, with no clock involved.
- R5: With `cfg_sync_oe` = 1, `drive` takes the inverse of `oe_n` as sampled at each rising clock edge. Between edges it keeps that value.
- R6: With `cfg_latch_en` = 0, `ale` has no effect, and the effective address equals `addr`.
- R7: With `cfg_latch_en` = 1, the effective address follows `addr` while the latch is open. It holds its last value while the latch is closed.
- R8: The latch is open when `ale` = 1 if `cfg_ale_low` = 0, and when `ale` = 0 if `cfg_ale_low` = 1.
- R9: Whenever `drive` is 0, `dout` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register, the enable sample and programming |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync_oe | input | 1 | 1: enable sampled on the clock; 0: enable acts directly |
| cfg_latch_en | input | 1 | 1: address passes through the latch |
| cfg_ale_low | input | 1 | 1: latch open while `ale` is low |
| addr | input | ADDR_W | Read address |
| ale | input | 1 | Address latch enable |
| oe_n | input | 1 | Active-low output enable |
| prog_mode | input | 1 | Test-only program mode |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | ADDR_W | Program word address |
| prog_data | input | 8 | Program word data |
| dout | output | 8 | Registered read data, zero when not driven |
| drive | output | 1 | Output drive active |

## Verification
The bench goes after a set of specific faults. Each is listed with the symptom a faulty design would show.

- **Address decode.** Every word of the array is read back in turn, and `ale` toggles during the pass. A decode slip, or a latch path that leaks into the non-latched configuration, returns the wrong word.
- **Enable timing.** A change of `oe_n` must reach `drive` at once in the asynchronous mode, and only at the next edge in the synchronous mode. A design that mixes up the two modes shows the change one clock early or one clock late.
- **Latch polarity.** Both polarities are exercised by opening the latch, closing it, and then changing `addr`. An inverted polarity, or a latch that never closes, shows the changed address instead of the held word.
- **Reset.** After reset the held address must be 0. A design that skips clearing it reads some other word.

// File: rtl/registered_rom.sv
module registered_rom #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sync_oe,
  input  logic              cfg_latch_en,
  input  logic              cfg_ale_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ale,
  input  logic              oe_n,
  input  logic              prog_mode,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] held_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] out_q;
  logic              en_q;
  logic              latch_open;

  assign latch_open = ale ^ cfg_ale_low;

  always_latch begin
    if (!rst_n)
      held_addr = '0;
    else if (latch_open)
      held_addr = addr;
  end

  assign eff_addr = (cfg_latch_en && !latch_open) ? held_addr : addr;

  always_ff @(posedge clk) begin
    if (prog_mode && prog_we)
      mem[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      en_q  <= 1'b0;
    end else begin
      out_q <= mem[eff_addr];
      en_q  <= ~oe_n;
    end
  end

  assign drive = cfg_sync_oe ? en_q : ~oe_n;
  assign dout  = drive ? out_q : '0;
endmodule

// File: rtl/registered_rom_checker.sv
module registered_rom_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_sync_oe,
  input logic              cfg_latch_en,
  input logic              cfg_ale_low,
  input logic              ale,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              drive,
  input logic [DATA_W-1:0] dout
);
  logic closed;
  assign closed = cfg_latch_en && (ale == cfg_ale_low);

  a_r4_async_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sync_oe |-> (drive == !oe_n));

  a_r5_sync_oe: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sync_oe |=> (drive == !$past(oe_n)));

  a_r6_flow: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_latch_en |-> (eff_addr == addr));

  // R7 and R8: a closed latch keeps the effective address
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && $past(closed)) |-> $stable(eff_addr));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (dout == '0));
endmodule

bind registered_rom registered_rom_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sync_oe(cfg_sync_oe), .cfg_latch_en(cfg_latch_en),
  .cfg_ale_low(cfg_ale_low), .ale(ale), .oe_n(oe_n), .addr(addr),
  .eff_addr(eff_addr), .drive(drive), .dout(dout));

// File: tb/registered_rom_tb_top.sv
module registered_rom_tb_top;
  localparam int AW = 11;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cfg_sync_oe = 0, cfg_latch_en = 0, cfg_ale_low = 0;
  logic [AW-1:0] addr = '0, prog_addr = '0;
  logic ale = 0, oe_n = 0, prog_mode = 0, prog_we = 0;
  logic [7:0] prog_data = '0, dout;
  logic drive;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  registered_rom #(.ADDR_W(AW), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sync_oe(cfg_sync_oe), .cfg_latch_en(cfg_latch_en),
    .cfg_ale_low(cfg_ale_low), .addr(addr), .ale(ale), .oe_n(oe_n),
    .prog_mode(prog_mode), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .dout(dout), .drive(drive));

  function automatic logic [7:0] f(int a);
    return 8'((a * 37 + (a >> 3)) ^ 'h5A);
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit s, bit l, bit p);
    rst_n = 0; cfg_sync_oe = s; cfg_latch_en = l; cfg_ale_low = p;
    tick(); tick();
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R3: reset clears register, asynchronous enable drives zero
    #3;
    chk("R3", {drive, dout}, {1'b1, 8'h00});
    do_reset(0, 0, 0);
    prog_mode = 1; prog_we = 1;
    for (int a = 0; a < N; a++) begin
      prog_addr = AW'(a); prog_data = f(a); tick();
    end
    prog_we = 0; prog_mode = 0;
    // R1 R2 R6: full sweep, ale toggling is ignored
    for (int a = 0; a < N; a++) begin
      addr = AW'(a); ale = a[0]; tick();
      chk("R2_R6", {drive, dout}, {1'b1, f(a)});
    end
    // R4 R9: asynchronous enable, no clock
    @(negedge clk); oe_n = 1; #1;
    chk("R4_R9", {drive, dout}, {1'b0, 8'h00});
    oe_n = 0; #1;
    chk("R4", {drive, dout}, {1'b1, f(N-1)});
    // R3 R5: synchronous enable
    oe_n = 0; do_reset(1, 0, 0);
    #1; chk("R3_R5", {drive, dout}, {1'b0, 8'h00});
    addr = AW'(7); tick();
    chk("R5", {drive, dout}, {1'b1, f(7)});
    oe_n = 1; #1;
    chk("R5_hold", {drive, dout}, {1'b1, f(7)});
    tick();
    chk("R5_R9", {drive, dout}, {1'b0, 8'h00});
    oe_n = 0; tick();
    // R3 R7 R8: latch active high, held address cleared by reset
    ale = 0; addr = AW'(100); do_reset(0, 1, 0);
    tick();
    chk("R3_R7", {drive, dout}, {1'b1, f(0)});
    for (int a = 0; a < 256; a++) begin
      ale = 1; addr = AW'(a * 7); tick();
      ale = 0; addr = ~AW'(a * 7); tick();
      chk("R7_R8_high", {drive, dout}, {1'b1, f((a * 7) % N)});
    end
    // R8: latch active low
    ale = 1; do_reset(0, 1, 1);
    for (int a = 0; a < 256; a++) begin
      ale = 0; addr = AW'(a * 5 + 3); tick();
      ale = 1; addr = AW'(a * 11); tick();
      chk("R7_R8_low", {drive, dout}, {1'b1, f((a * 5 + 3) % N)});
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule